// File: doc/BRIEF.md
# Program memory table access unit

This unit bridges a 16-bit data path to a memory built from 24-bit instruction words. A single request carries an operation code, a byte/word mode flag, an 8-bit page value and a 16-bit effective address. The unit turns this into a memory word index, a read strobe, or a set of per-byte write enables with positioned write data. Read results come back one cycle after the request is accepted.

The 24-bit word is shown to the data path as two 16-bit views that share the same addresses. The low view holds program bits 15:0. The high view holds program bits 23:16 in its low byte, and its upper byte is a phantom byte: it always reads as zero, and writes to it are dropped. Effective addresses step by two per program word, so address bit 0 selects a byte rather than a word. The top bit of the page value chooses between the user region and the configuration region of the memory.

Top module: `tbl_access_unit`

## Requirements
- R1: For every accepted request, mem_addr equals {req_page, req_ea[15:1]}. Its MSB, page bit 7, is 0 for user space and 1 for configuration space. req_ea[0] is the byte-select bit.
- R2: A low read (req_op=2'b00) in word mode (req_byte=0) returns program bits 15:0 as rsp_data.
- R3: A low read in byte mode (req_byte=1) returns program bits 15:8 in rsp_data[7:0] when byte-select is 1, and program bits 7:0 when byte-select is 0. rsp_data[15:8] is zero.
- R4: A high read (req_op=2'b01) in word mode returns {8'h00, program bits 23:16}.
- R5: A high read in byte mode returns {8'h00, program bits 23:16} when byte-select is 0, and 16'h0000 when byte-select is 1.
- R6: A low write (req_op=2'b10) in word mode drives mem_be=3'b011 with mem_wdata[15:0]=req_wdata. mem_be bit 2 enables bits 23:16, bit 1 enables bits 15:8 and bit 0 enables bits 7:0.
- R7: A low write in byte mode drives mem_be=3'b010 with mem_wdata[15:8]=req_wdata[7:0] when byte-select is 1. It drives mem_be=3'b001 with mem_wdata[7:0]=req_wdata[7:0] when byte-select is 0.
- R8: A high write (req_op=2'b11) in word mode, or in byte mode with byte-select 0, drives mem_be=3'b100 with mem_wdata[23:16]=req_wdata[7:0].
- R9: A high write in byte mode with byte-select 1 targets the phantom byte. It drives mem_be=3'b000 and leaves memory unchanged.
- R10: req_ready is low during reset and high after it. When a read is accepted in cycle N, mem_rd_en is high in cycle N and rsp_done is high with valid rsp_data in cycle N+1. Writes never raise rsp_done or mem_rd_en. rsp_done is low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_op | input | 2 | 00 low read, 01 high read, 10 low write, 11 high write |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| req_page | input | 8 | Page value, upper address bits |
| req_ea | input | 16 | Effective address; bit 0 is byte-select |
| req_wdata | input | 16 | Write data from the data path |
| rsp_done | output | 1 | Read result valid |
| rsp_data | output | 16 | Read result |
| mem_addr | output | 23 | Memory word index |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_be | output | 3 | Per-byte write enables toward the memory |
| mem_wdata | output | 24 | Write data positioned in byte lanes |
| mem_rdata | input | 24 | Memory read data, one cycle after mem_rd_en |

## Verification
The hardest case to reach is the silent phantom write. Its only visible effects are an all-zero enable vector and a memory word that does not change. The stimulus therefore follows each phantom write with an immediate high and low read of the same word. Any stray lane enable then shows up as a changed result. Back-to-back mixed reads and writes, including a read right after a write to the same word, check the one-cycle response timing under full load. They also check that a new request in the response cycle cannot disturb the result being returned.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
   typedef enum logic [1:0] {
      OP_RD_LO = 2'b00,
      OP_RD_HI = 2'b01,
      OP_WR_LO = 2'b10,
      OP_WR_HI = 2'b11
   } tbl_op_e;

   localparam int unsigned LANES = 3;

   function automatic logic op_is_read(input tbl_op_e op);
      return ~op[1];
   endfunction

   function automatic logic op_is_high(input tbl_op_e op);
      return op[0];
   endfunction
endpackage

// File: rtl/tbl_addr_gen.sv
module tbl_addr_gen #(
   parameter int unsigned PAGE_W = 8,
   parameter int unsigned EA_W   = 16,
   localparam int unsigned ADDR_W = PAGE_W + EA_W - 1
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [EA_W-1:0]   ea,
   output logic [ADDR_W-1:0] word_addr,
   output logic              byte_sel
);
   if (EA_W < 2) begin : g_bad_ea
      $error("tbl_addr_gen: EA_W must be at least 2");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("tbl_addr_gen: PAGE_W must be at least 1");
   end

   // Addresses advance by two per program word: bit 0 picks a byte.
   always_comb begin
      word_addr = {page, ea[EA_W-1:1]};
      byte_sel  = ea[0];
   end
endmodule

// File: rtl/tbl_wr_lane.sv
module tbl_wr_lane
   import tbl_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DATA_W = 2 * LANE_W,
   localparam int unsigned WORD_W = LANES * LANE_W
) (
   input  logic              fire,
   input  tbl_op_e           op,
   input  logic              byte_mode,
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be,
   output logic [WORD_W-1:0] lane_data
);
   logic [LANES-1:0] lane_hit;

   // Lane choice per write flavour; the phantom byte maps to no lane.
   always_comb begin
      lane_hit = '0;
      unique case (op)
         OP_WR_LO: lane_hit = byte_mode ? (byte_sel ? 3'b010 : 3'b001) : 3'b011;
         OP_WR_HI: lane_hit = (byte_mode && byte_sel) ? 3'b000 : 3'b100;
         default:  lane_hit = 3'b000;
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] src;
      if (g == 1) begin : g_mid
         // Middle lane takes the upper data byte in word mode,
         // the single data byte in byte mode.
         assign src = byte_mode ? wdata[LANE_W-1:0] : wdata[DATA_W-1:LANE_W];
      end else begin : g_edge
         assign src = wdata[LANE_W-1:0];
      end
      assign lane_data[g*LANE_W +: LANE_W] = src;
      assign be[g] = fire & lane_hit[g];
   end
endmodule

// File: rtl/tbl_rd_fmt.sv
module tbl_rd_fmt #(
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DATA_W = 2 * LANE_W,
   localparam int unsigned WORD_W = 3 * LANE_W
) (
   input  logic              high_view,
   input  logic              byte_mode,
   input  logic              byte_sel,
   input  logic [WORD_W-1:0] word,
   output logic [DATA_W-1:0] result
);
   logic [LANE_W-1:0] b_lo, b_mid, b_top;

   always_comb begin
      b_lo  = word[LANE_W-1:0];
      b_mid = word[2*LANE_W-1:LANE_W];
      b_top = word[3*LANE_W-1:2*LANE_W];
      unique case ({high_view, byte_mode})
         2'b00: result = {b_mid, b_lo};
         2'b01: result = {{LANE_W{1'b0}}, (byte_sel ? b_mid : b_lo)};
         2'b10: result = {{LANE_W{1'b0}}, b_top};
         default: result = {{LANE_W{1'b0}}, (byte_sel ? {LANE_W{1'b0}} : b_top)};
      endcase
   end
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit
   import tbl_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned PAGE_W = 8,
   parameter int unsigned EA_W   = 16,
   localparam int unsigned DATA_W = 2 * LANE_W,
   localparam int unsigned WORD_W = LANES * LANE_W,
   localparam int unsigned ADDR_W = PAGE_W + EA_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic              req_byte,
   input  logic [PAGE_W-1:0] req_page,
   input  logic [EA_W-1:0]   req_ea,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   output logic [LANES-1:0]  mem_be,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata
);
   if (LANE_W < 1) begin : g_bad_lane
      $error("tbl_access_unit: LANE_W must be at least 1");
   end

   tbl_op_e     op;
   logic        fire;
   logic        rd_req;
   logic        bsel;
   logic        ready_q;
   logic        done_q, hi_q, byte_q, bsel_q;
   logic [DATA_W-1:0] fmt_data;

   assign op     = tbl_op_e'(req_op);
   assign fire   = req_valid & ready_q;
   assign rd_req = op_is_read(op);

   always_ff @(posedge clk) begin
      if (rst) ready_q <= 1'b0;
      else     ready_q <= 1'b1;
   end
   assign req_ready = ready_q;

   tbl_addr_gen #(.PAGE_W(PAGE_W), .EA_W(EA_W)) addr_i (
      .page      (req_page),
      .ea        (req_ea),
      .word_addr (mem_addr),
      .byte_sel  (bsel)
   );

   tbl_wr_lane #(.LANE_W(LANE_W)) wr_i (
      .fire      (fire),
      .op        (op),
      .byte_mode (req_byte),
      .byte_sel  (bsel),
      .wdata     (req_wdata),
      .be        (mem_be),
      .lane_data (mem_wdata)
   );

   assign mem_rd_en = fire & rd_req;

   // Response context follows the memory's one-cycle latency.
   always_ff @(posedge clk) begin
      if (rst) begin
         done_q <= 1'b0;
         hi_q   <= 1'b0;
         byte_q <= 1'b0;
         bsel_q <= 1'b0;
      end else begin
         done_q <= fire & rd_req;
         if (fire & rd_req) begin
            hi_q   <= op_is_high(op);
            byte_q <= req_byte;
            bsel_q <= bsel;
         end
      end
   end

   tbl_rd_fmt #(.LANE_W(LANE_W)) fmt_i (
      .high_view (hi_q),
      .byte_mode (byte_q),
      .byte_sel  (bsel_q),
      .word      (mem_rdata),
      .result    (fmt_data)
   );

   assign rsp_done = done_q;
   assign rsp_data = done_q ? fmt_data : '0;

   // R9: phantom write reaches no lane
   a_r9_phantom_no_be: assert property (@(posedge clk) disable iff (rst)
      (fire && op == OP_WR_HI && req_byte && req_ea[0]) |-> (mem_be == '0));

   // R7: low writes never touch the top lane
   a_r7_lo_write_no_top: assert property (@(posedge clk) disable iff (rst)
      (fire && op == OP_WR_LO) |-> !mem_be[LANES-1]);

   // R8: high writes touch only the top lane
   a_r8_hi_write_top_only: assert property (@(posedge clk) disable iff (rst)
      (fire && op == OP_WR_HI) |-> (mem_be[1:0] == 2'b00));

   // R10: accepted read answers next cycle
   a_r10_done_next: assert property (@(posedge clk) disable iff (rst)
      (fire && rd_req) |=> rsp_done);

   // R10: done only follows a memory read
   a_r10_done_cause: assert property (@(posedge clk) disable iff (rst)
      rsp_done |-> $past(mem_rd_en));

   // R10: reads and writes are exclusive at the memory port
   a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en |-> (mem_be == '0));

   // R3 R4: byte-mode and high-view results keep the upper byte at zero
   a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (rsp_done && (hi_q || byte_q)) |-> (rsp_data[DATA_W-1:LANE_W] == '0));

   // R5: phantom byte reads as zero
   a_r5_phantom_read_zero: assert property (@(posedge clk) disable iff (rst)
      (rsp_done && hi_q && byte_q && bsel_q) |-> (rsp_data == '0));
endmodule

// File: tb/tbl_access_unit_tb.sv
module tbl_access_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic [1:0]  req_op;
   logic        req_byte;
   logic [7:0]  req_page;
   logic [15:0] req_ea;
   logic [15:0] req_wdata;
   logic        rsp_done;
   logic [15:0] rsp_data;
   logic [22:0] mem_addr;
   logic        mem_rd_en;
   logic [2:0]  mem_be;
   logic [23:0] mem_wdata;
   logic [23:0] mem_rdata;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;   // 250 MHz

   tbl_access_unit dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_byte(req_byte), .req_page(req_page), .req_ea(req_ea),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_data(rsp_data),
      .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [23:0] seed_word(input logic [22:0] a);
      return {a[7:0] ^ 8'h5A, a[15:8] + 8'h33 + a[22:16], a[7:0] + 8'hC1};
   endfunction

   // Memory seen by the unit
   logic [23:0] mem_model [logic [22:0]];
   // Expected contents, kept from the requirements
   logic [23:0] ref_mem [logic [22:0]];

   function automatic logic [23:0] model_get(input logic [22:0] a);
      if (mem_model.exists(a)) return mem_model[a];
      return seed_word(a);
   endfunction

   function automatic logic [23:0] ref_get(input logic [22:0] a);
      if (ref_mem.exists(a)) return ref_mem[a];
      return seed_word(a);
   endfunction

   always @(posedge clk) begin
      logic [23:0] w;
      if (mem_rd_en) mem_rdata <= model_get(mem_addr);
      if (mem_be != 3'b000) begin
         w = model_get(mem_addr);
         for (int i = 0; i < 3; i++)
            if (mem_be[i]) w[i*8 +: 8] = mem_wdata[i*8 +: 8];
         mem_model[mem_addr] = w;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   logic [15:0] exp_q[$];
   string       tag_q[$];

   task automatic issue(input logic [1:0] op, input logic byt, input logic [7:0] page,
                        input logic [15:0] ea, input logic [15:0] wd);
      logic [22:0] a;
      logic [23:0] w;
      logic [15:0] e;
      logic [2:0]  ebe;
      logic        bs;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_byte = byt;
      req_page = page; req_ea = ea; req_wdata = wd;
      #1;
      a  = {page, ea[15:1]};
      bs = ea[0];
      check(mem_addr == a, "R1", "word address", 32'(mem_addr), 32'(a));
      check(mem_addr[22] == page[7], "R1", "space select bit", 32'(mem_addr[22]), 32'(page[7]));
      w = ref_get(a);
      if (!op[1]) begin
         check(mem_rd_en && mem_be == 3'b000, "R10", "read strobe", {28'h0, mem_rd_en, mem_be}, 32'h8);
         case ({op[0], byt})
            2'b00: begin e = w[15:0]; tag_q.push_back("R2"); end
            2'b01: begin e = {8'h00, bs ? w[15:8] : w[7:0]}; tag_q.push_back("R3"); end
            2'b10: begin e = {8'h00, w[23:16]}; tag_q.push_back("R4"); end
            default: begin e = bs ? 16'h0 : {8'h00, w[23:16]}; tag_q.push_back("R5"); end
         endcase
         exp_q.push_back(e);
      end else begin
         check(!mem_rd_en, "R10", "no read strobe on write", 32'(mem_rd_en), 32'h0);
         if (!op[0]) begin
            ebe = byt ? (bs ? 3'b010 : 3'b001) : 3'b011;
            check(mem_be == ebe, byt ? "R7" : "R6", "byte enables", 32'(mem_be), 32'(ebe));
            if (!byt) begin
               check(mem_wdata[15:0] == wd, "R6", "low word data", 32'(mem_wdata[15:0]), 32'(wd));
               w[15:0] = wd;
            end else if (bs) begin
               check(mem_wdata[15:8] == wd[7:0], "R7", "byte lane 1", 32'(mem_wdata[15:8]), 32'(wd[7:0]));
               w[15:8] = wd[7:0];
            end else begin
               check(mem_wdata[7:0] == wd[7:0], "R7", "byte lane 0", 32'(mem_wdata[7:0]), 32'(wd[7:0]));
               w[7:0] = wd[7:0];
            end
         end else if (byt && bs) begin
            check(mem_be == 3'b000, "R9", "phantom write enables", 32'(mem_be), 32'h0);
         end else begin
            check(mem_be == 3'b100, "R8", "high write enables", 32'(mem_be), 32'h4);
            check(mem_wdata[23:16] == wd[7:0], "R8", "top lane data", 32'(mem_wdata[23:16]), 32'(wd[7:0]));
            w[23:16] = wd[7:0];
         end
         ref_mem[a] = w;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: results are due exactly one cycle after a read is accepted
   always @(negedge clk) begin
      if (!rst) begin
         if (rsp_done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10", "unexpected done", 32'(rsp_data), 32'h0);
            end else begin
               logic [15:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(rsp_data == e, t, "read result", 32'(rsp_data), 32'(e));
            end
         end else if (exp_q.size() != 0) begin
            check(1'b0, "R10", "done missing", 32'(rsp_done), 32'h1);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   initial begin
      #100000;
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog expired: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      rst = 1'b1; req_valid = 1'b0; req_op = 2'b00; req_byte = 1'b0;
      req_page = 8'h00; req_ea = 16'h0; req_wdata = 16'h0; mem_rdata = 24'h0;
      repeat (3) @(negedge clk);
      check(rsp_done == 1'b0, "R10", "done in reset", 32'(rsp_done), 32'h0);
      check(req_ready == 1'b0, "R10", "ready in reset", 32'(req_ready), 32'h0);
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check(req_ready == 1'b1, "R10", "ready after reset", 32'(req_ready), 32'h1);

      // Reads of seeded contents, all view/mode/select combinations
      issue(2'b00, 1'b0, 8'h02, 16'h0010, 16'h0); idle();
      issue(2'b00, 1'b1, 8'h02, 16'h0010, 16'h0); idle();
      issue(2'b00, 1'b1, 8'h02, 16'h0011, 16'h0); idle();
      issue(2'b01, 1'b0, 8'h02, 16'h0010, 16'h0); idle();
      issue(2'b01, 1'b1, 8'h02, 16'h0010, 16'h0); idle();
      issue(2'b01, 1'b1, 8'h02, 16'h0011, 16'h0); idle();
      issue(2'b01, 1'b0, 8'h03, 16'h0011, 16'h0); idle();
      // Configuration space pages
      issue(2'b00, 1'b0, 8'h80, 16'hFFFE, 16'h0); idle();
      issue(2'b01, 1'b0, 8'hFF, 16'h1234, 16'h0); idle();

      // Writes followed by readback
      issue(2'b10, 1'b0, 8'h01, 16'h0040, 16'hBEEF);
      issue(2'b00, 1'b0, 8'h01, 16'h0040, 16'h0);
      issue(2'b01, 1'b0, 8'h01, 16'h0040, 16'h0); idle();
      issue(2'b10, 1'b1, 8'h01, 16'h0041, 16'h00A5);
      issue(2'b00, 1'b0, 8'h01, 16'h0040, 16'h0);
      issue(2'b10, 1'b1, 8'h01, 16'h0040, 16'h773C);
      issue(2'b00, 1'b0, 8'h01, 16'h0040, 16'h0);
      issue(2'b11, 1'b0, 8'h01, 16'h0040, 16'hFF96);
      issue(2'b01, 1'b0, 8'h01, 16'h0040, 16'h0);
      issue(2'b11, 1'b1, 8'h01, 16'h0040, 16'h0042);
      issue(2'b01, 1'b1, 8'h01, 16'h0040, 16'h0);
      // Phantom write then readback of both views
      issue(2'b11, 1'b1, 8'h01, 16'h0041, 16'hFFFF);
      issue(2'b01, 1'b0, 8'h01, 16'h0041, 16'h0);
      issue(2'b00, 1'b0, 8'h01, 16'h0040, 16'h0);
      issue(2'b01, 1'b1, 8'h01, 16'h0041, 16'h0); idle();
      // Phantom write on a config page, unseen word
      issue(2'b11, 1'b1, 8'h85, 16'h0203, 16'h5555);
      issue(2'b01, 1'b0, 8'h85, 16'h0203, 16'h0);
      issue(2'b00, 1'b0, 8'h85, 16'h0202, 16'h0); idle();

      // Back-to-back mixed traffic over a small address window
      lf = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         issue(lf[1:0], lf[2], {lf[15], 4'h0, lf[5:3]}, {12'h0, lf[9:6]}, {lf[7:0], lf[15:8]});
         if (lf[11] && lf[12]) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10", "pending results at end", 32'(exp_q.size()), 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule